// File: doc/BRIEF.md
# Multi-node packet route table

This block is the routing lookup of one node in a small point-to-point coherent fabric. It keeps one route entry per destination node. Each entry holds three 4-bit port vectors, one for each packet class (request, response, broadcast). A port vector names the local node and up to three outgoing links. Software loads the entries through a single-cycle register write port and can read any entry back at any time.

On each lookup the fabric presents a destination node and a packet class. One cycle later the block returns a registered port vector with a valid strobe. Request and response routes are meant to name exactly one port. If an entry names more than one, the lowest port wins and an error flag is raised. A broadcast route may fan out to several ports in the same cycle. A global bypass input makes every packet ignore the table and follow a fixed default link code instead.

Top module: `node_route_table`

## Requirements
- R1: After reset every entry reads back as 0x00010101, so every class routes to the local node only, and res_valid_o is 0.
- R2: A write with wr_en_i high stores wr_data_i bits [3:0] (request route), [11:8] (response route) and [19:16] (broadcast route) into entry wr_idx_i. The stored value is visible on rd_data_o for rd_idx_i from the next cycle. All other bits read as 0, whatever was written to them.
- R3: In every route field and in res_ports_o, bit 0 means deliver to the local node, and bits 1, 2 and 3 mean forward on link 0, link 1 and link 2.
- R4: Class code 0 (request) selects the entry's request field, code 1 (response) its response field and code 2 (broadcast) its broadcast field. Code 3 returns an all-zero port vector with no error. An entry that is never written keeps its reset route.
- R5: The result is due one cycle after a lookup. res_valid_o is high in exactly the cycle after lk_valid_i was high, and res_ports_o and res_err_o are 0 whenever res_valid_o is 0.
- R6: A broadcast lookup returns the broadcast field unchanged, so several ports can be asserted in the same cycle, with res_err_o at 0.
- R7: For a request or response lookup whose field has two or more bits set, only the lowest set bit is returned and res_err_o is 1. A field with zero bits or one bit set gives res_err_o = 0 and the field itself.
- R8: While tbl_off_i is 1, every class ignores the table and returns one port selected by dflt_link_i, with res_err_o at 0. Code 00 selects link 0 (bit 1), 01 selects link 1 (bit 2), 10 selects link 2 (bit 3) and 11 selects the local node (bit 0).
- R9: A lookup in the same cycle as a write to the same entry uses the entry's old contents. The next lookup uses the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Entry write strobe |
| wr_idx_i | input | 3 | Entry written |
| wr_data_i | input | 32 | Write data (route fields at [3:0], [11:8], [19:16]) |
| rd_idx_i | input | 3 | Entry shown on rd_data_o |
| rd_data_o | output | 32 | Readback of entry rd_idx_i |
| tbl_off_i | input | 1 | 1 = bypass table, use default link |
| dflt_link_i | input | 2 | Default link code |
| lk_valid_i | input | 1 | Lookup request strobe |
| lk_node_i | input | 3 | Destination node of the packet |
| lk_class_i | input | 2 | Packet class: 0 request, 1 response, 2 broadcast, 3 none |
| res_valid_o | output | 1 | Lookup result valid |
| res_ports_o | output | 4 | Selected ports: bit 0 local, bits 1..3 links 0..2 |
| res_err_o | output | 1 | Unicast route had more than one port set |

## Verification
Readback is combinational on the stored entries, so a write becomes visible one cycle after its strobe. A lookup result is registered, so it is due one cycle after the lookup strobe. The bench drives every input on the falling edge. It samples each lookup result on the next falling edge, after exactly one rising edge. It samples readback a short delay after setting the read index, in a cycle after the write's edge. The same-cycle case drives a write and a lookup of the same entry on one falling edge. It then checks that the result sampled one edge later still carries the old route, and that a second lookup carries the new one.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int unsigned RT_PORT_W  = 4;
  localparam int unsigned RT_REQ_LSB = 0;
  localparam int unsigned RT_RSP_LSB = 8;
  localparam int unsigned RT_BC_LSB  = 16;

  typedef enum logic [1:0] {
    CLS_REQ  = 2'd0,
    CLS_RSP  = 2'd1,
    CLS_BC   = 2'd2,
    CLS_NONE = 2'd3
  } pkt_class_e;

  typedef struct packed {
    logic [RT_PORT_W-1:0] bc;
    logic [RT_PORT_W-1:0] rsp;
    logic [RT_PORT_W-1:0] req;
  } route_entry_t;

  localparam route_entry_t RT_RESET_ENTRY = '{bc: 4'b0001, rsp: 4'b0001, req: 4'b0001};

  // keep only the lowest set bit
  function automatic logic [RT_PORT_W-1:0] lowest_bit(input logic [RT_PORT_W-1:0] v);
    return v & (~v + RT_PORT_W'(1));
  endfunction

  function automatic logic multi_bit(input logic [RT_PORT_W-1:0] v);
    return (v & (v - RT_PORT_W'(1))) != '0;
  endfunction
endpackage

// File: rtl/rt_store.sv
module rt_store
  import rt_pkg::*;
#(
  parameter int unsigned NODES  = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(NODES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output route_entry_t      ent_o [NODES]
);
  route_entry_t wr_ent;

  always_comb begin
    wr_ent.req = wr_data_i[RT_REQ_LSB +: RT_PORT_W];
    wr_ent.rsp = wr_data_i[RT_RSP_LSB +: RT_PORT_W];
    wr_ent.bc  = wr_data_i[RT_BC_LSB  +: RT_PORT_W];
  end

  for (genvar n = 0; n < NODES; n++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_o[n] <= RT_RESET_ENTRY;
      end else if (wr_en_i && wr_idx_i == IDX_W'(n)) begin
        ent_o[n] <= wr_ent;
      end
    end
  end
endmodule

// File: rtl/rt_select.sv
module rt_select
  import rt_pkg::*;
(
  input  route_entry_t         ent_i,
  input  pkt_class_e           cls_i,
  input  logic                 tbl_off_i,
  input  logic [1:0]           dflt_link_i,
  output logic [RT_PORT_W-1:0] ports_o,
  output logic                 err_o
);
  logic [RT_PORT_W-1:0] dflt_ports;

  // code 3 = local node, codes 0..2 = links 0..2 at bits 1..3
  always_comb begin
    dflt_ports = '0;
    if (dflt_link_i == 2'd3) dflt_ports[0] = 1'b1;
    else                     dflt_ports[dflt_link_i + 2'd1] = 1'b1;
  end

  always_comb begin
    ports_o = '0;
    err_o   = 1'b0;
    if (tbl_off_i) begin
      ports_o = dflt_ports;
    end else begin
      unique case (cls_i)
        CLS_REQ: begin
          ports_o = lowest_bit(ent_i.req);
          err_o   = multi_bit(ent_i.req);
        end
        CLS_RSP: begin
          ports_o = lowest_bit(ent_i.rsp);
          err_o   = multi_bit(ent_i.rsp);
        end
        CLS_BC:   ports_o = ent_i.bc;
        default:  ports_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/node_route_table.sv
module node_route_table
  import rt_pkg::*;
#(
  parameter int unsigned NODES  = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(NODES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic [IDX_W-1:0]     rd_idx_i,
  output logic [DATA_W-1:0]    rd_data_o,
  input  logic                 tbl_off_i,
  input  logic [1:0]           dflt_link_i,
  input  logic                 lk_valid_i,
  input  logic [IDX_W-1:0]     lk_node_i,
  input  logic [1:0]           lk_class_i,
  output logic                 res_valid_o,
  output logic [RT_PORT_W-1:0] res_ports_o,
  output logic                 res_err_o
);
  route_entry_t         ent [NODES];
  route_entry_t         rd_ent;
  logic [RT_PORT_W-1:0] sel_ports;
  logic                 sel_err;

  rt_store #(.NODES(NODES), .DATA_W(DATA_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .ent_o     (ent)
  );

  always_comb begin
    rd_ent    = ent[rd_idx_i];
    rd_data_o = '0;
    rd_data_o[RT_REQ_LSB +: RT_PORT_W] = rd_ent.req;
    rd_data_o[RT_RSP_LSB +: RT_PORT_W] = rd_ent.rsp;
    rd_data_o[RT_BC_LSB  +: RT_PORT_W] = rd_ent.bc;
  end

  rt_select u_sel (
    .ent_i       (ent[lk_node_i]),
    .cls_i       (pkt_class_e'(lk_class_i)),
    .tbl_off_i   (tbl_off_i),
    .dflt_link_i (dflt_link_i),
    .ports_o     (sel_ports),
    .err_o       (sel_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_ports_o <= '0;
      res_err_o   <= 1'b0;
    end else begin
      res_valid_o <= lk_valid_i;
      res_ports_o <= lk_valid_i ? sel_ports : '0;
      res_err_o   <= lk_valid_i & sel_err;
    end
  end
endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
  parameter int unsigned IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tbl_off_i,
  input logic             lk_valid_i,
  input logic [1:0]       lk_class_i,
  input logic             res_valid_o,
  input logic [3:0]       res_ports_o,
  input logic             res_err_o
);
  a_r5_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> res_valid_o);
  a_r5_valid_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !res_valid_o);
  a_r5_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> (res_ports_o == 4'd0 && !res_err_o));
  a_r7_unicast_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && !tbl_off_i && lk_class_i != 2'd2) |=> $onehot0(res_ports_o));
  a_r8_bypass_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && tbl_off_i) |=> ($countones(res_ports_o) == 1 && !res_err_o));
endmodule

bind node_route_table rt_checker #(.IDX_W(IDX_W)) u_rt_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tbl_off_i   (tbl_off_i),
  .lk_valid_i  (lk_valid_i),
  .lk_class_i  (lk_class_i),
  .res_valid_o (res_valid_o),
  .res_ports_o (res_ports_o),
  .res_err_o   (res_err_o)
);

// File: tb/test_node_route_table.sv
`timescale 1ns/1ps
module test_node_route_table;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        tbl_off = 1'b0;
  logic [1:0]  dflt = '0;
  logic        lk_valid = 1'b0;
  logic [2:0]  lk_node = '0;
  logic [1:0]  lk_class = '0;
  logic        res_valid;
  logic [3:0]  res_ports;
  logic        res_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  node_route_table i_node_route_table (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .tbl_off_i(tbl_off), .dflt_link_i(dflt),
    .lk_valid_i(lk_valid), .lk_node_i(lk_node), .lk_class_i(lk_class),
    .res_valid_o(res_valid), .res_ports_o(res_ports), .res_err_o(res_err)
  );

  // {off, dflt[1:0], node[2:0], class[1:0], exp_ports[3:0], exp_err}
  localparam int NV = 17;
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 2'd0, 3'd0, 2'd0, 4'h1, 1'b0},
    {1'b0, 2'd0, 3'd0, 2'd2, 4'h1, 1'b0},
    {1'b0, 2'd0, 3'd1, 2'd0, 4'h2, 1'b0},
    {1'b0, 2'd0, 3'd1, 2'd1, 4'h4, 1'b0},
    {1'b0, 2'd0, 3'd1, 2'd2, 4'hE, 1'b0},
    {1'b0, 2'd0, 3'd2, 2'd0, 4'h2, 1'b1},
    {1'b0, 2'd0, 3'd2, 2'd1, 4'h0, 1'b0},
    {1'b0, 2'd0, 3'd2, 2'd2, 4'hF, 1'b0},
    {1'b0, 2'd0, 3'd7, 2'd0, 4'h8, 1'b0},
    {1'b0, 2'd0, 3'd7, 2'd1, 4'h4, 1'b1},
    {1'b0, 2'd0, 3'd7, 2'd2, 4'h9, 1'b0},
    {1'b0, 2'd0, 3'd7, 2'd3, 4'h0, 1'b0},
    {1'b1, 2'd0, 3'd2, 2'd0, 4'h2, 1'b0},
    {1'b1, 2'd1, 3'd7, 2'd2, 4'h4, 1'b0},
    {1'b1, 2'd2, 3'd1, 2'd1, 4'h8, 1'b0},
    {1'b1, 2'd3, 3'd2, 2'd2, 4'h1, 1'b0},
    {1'b0, 2'd0, 3'd3, 2'd1, 4'h1, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_entry(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // drive at falling edge, result registered on the next rising edge, sample at next falling edge
  task automatic lookup(input logic off, input logic [1:0] dl, input logic [2:0] node,
                        input logic [1:0] cls);
    @(negedge clk);
    tbl_off = off; dflt = dl; lk_node = node; lk_class = cls; lk_valid = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic readback(input string req, input logic [2:0] idx, input logic [31:0] exp);
    rd_idx = idx;
    #1;
    check(req, rd_data, exp);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 8; i++) readback("R1", 3'(i), 32'h0001_0101);
    check("R1 valid", {31'd0, res_valid}, 32'd0);

    // R2 program entries, junk in reserved bits must vanish
    write_entry(3'd1, 32'hFFFE_F4F2);
    readback("R2", 3'd1, 32'h000E_0402);
    write_entry(3'd2, 32'h000F_0006);
    readback("R2", 3'd2, 32'h000F_0006);
    write_entry(3'd7, 32'hF009_FC08);
    readback("R2", 3'd7, 32'h0009_0C08);
    readback("R2 untouched", 3'd3, 32'h0001_0101);

    // R3/R4/R6/R7/R8 vector walk
    for (int v = 0; v < NV; v++) begin
      string tag;
      logic [12:0] e;
      e = VEC[v];
      lookup(e[12], e[11:10], e[9:7], e[6:5]);
      if (e[12])           tag = "R8";
      else if (e[6:5] == 2) tag = "R6";
      else if (e[0])       tag = "R7";
      else                 tag = "R4 R3";
      check({tag, " ports"}, {28'd0, res_ports}, {28'd0, e[4:1]});
      check({tag, " err"}, {31'd0, res_err}, {31'd0, e[0]});
      check("R5 valid", {31'd0, res_valid}, 32'd1);
    end
    tbl_off = 1'b0;

    // R5 valid and outputs drop one cycle after strobe ends
    @(negedge clk);
    check("R5 idle valid", {31'd0, res_valid}, 32'd0);
    check("R5 idle ports", {28'd0, res_ports}, 32'd0);

    // R9 same-cycle write and lookup of entry 1
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd1; wr_data = 32'h0000_0001;
    lk_valid = 1'b1; lk_node = 3'd1; lk_class = 2'd0;
    @(negedge clk);
    wr_en = 1'b0; lk_valid = 1'b0;
    check("R9 old route", {28'd0, res_ports}, 32'h2);
    lookup(1'b0, 2'd0, 3'd1, 2'd0);
    check("R9 new route", {28'd0, res_ports}, 32'h1);

    // R1 reset again clears entries and result
    rst_n = 1'b0;
    #2;
    rst_n = 1'b1;
    readback("R1 re-reset", 3'd7, 32'h0001_0101);
    check("R1 re-reset valid", {31'd0, res_valid}, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule